// File: doc/BRIEF.md
# SDRAM Command Timing Gate

This block sits between an SDRAM command scheduler and the memory command bus. The scheduler presents one request at a time: a command code and a target component bank. It holds that request until the gate answers with a one-cycle grant. The gate grants a request only when every minimum spacing that applies to it has run out. These spacings are activate-to-precharge, activate-to-column, precharge-to-activate, refresh-to-refresh/activate and activate-to-activate. The gate also refuses to place two activates to different banks without a column command between them.

The spacings come from one packed 32-bit configuration word. The word only takes effect on a rising edge of a separate program strobe, and all fields are captured together on that edge. Reserved codes are replaced by the slowest legal setting, and a sticky error flag records that one was captured. The gate also produces a read-data-valid strobe that follows each granted read by exactly the programmed CAS latency, and several reads may be in flight at once.

Top module: `sdram_cmd_gate`

## Requirements
- R1: Configuration fields: CAS latency at bits 30:28, refresh cycle spacing at 27:24, activate-to-precharge at 23:20, precharge-to-activate at 18:16, activate-to-column at 14:12, activate-to-activate at 10:8. A 4-bit code n (1..15) means n+1 clocks. A 3-bit spacing code n (1..7) means n clocks. CAS codes 2..7 mean 2..7 clocks.
- R2: cfg_word is captured only at a clock edge where cfg_prog is 1 after having been 0 at the previous edge. Reset treats cfg_prog as already high, so a strobe held high through reset captures nothing.
- R3: After reset, grant, rdata_valid and config_error are 0 and the active timing equals word 0x2A733225 (CAS 2, refresh cycle 11, activate-to-precharge 8, precharge-to-activate 3, activate-to-column 3, activate-to-activate 2).
- R4: A PRECHARGE to a bank is granted no sooner than the activate-to-precharge count of clocks after the last ACTIVATE to that bank.
- R5: A READ or WRITE to a bank is granted no sooner than the activate-to-column count of clocks after the last ACTIVATE to that bank.
- R6: An ACTIVATE to a bank is granted no sooner than the precharge-to-activate count of clocks after the last PRECHARGE to that bank.
- R7: A REFRESH or ACTIVATE is granted no sooner than the refresh cycle count of clocks after the last REFRESH.
- R8: An ACTIVATE to a bank other than the last activated one waits the activate-to-activate count after the previous ACTIVATE. Per-bank spacings of one bank never delay another bank.
- R9: After an ACTIVATE, an ACTIVATE to a different bank is refused until a READ or WRITE has been granted. PRECHARGE and REFRESH do not release this hold.
- R10: Command codes are 0 idle, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH. grant is high only in a cycle with req_valid high and a code from 1 to 5. Codes 0, 6 and 7 are never granted.
- R11: A READ granted in cycle t makes rdata_valid high in cycle t+CAS, for one cycle per read. Back-to-back reads give back-to-back strobes.
- R12: A captured reserved code (0 in any spacing field, 0 or 1 for CAS) selects that field's slowest setting (16, 7 or 7 clocks) and sets config_error. config_error stays set until reset.
- R13: Bits 31, 19, 15 and 11 of cfg_word have no effect on timing or on config_error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Packed timing configuration |
| cfg_prog | input | 1 | Program strobe; a rising edge captures cfg_word |
| req_valid | input | 1 | A command request is presented |
| req_cmd | input | 3 | Command code |
| req_bank | input | BANK_W (2) | Target component bank |
| grant | output | 1 | The presented request is issued this cycle |
| rdata_valid | output | 1 | Read data is due this cycle |
| config_error | output | 1 | Sticky flag: a reserved code was captured |

## Verification
The bench measures the cycle distance between two grants for each spacing. It uses the reset word, a word with extreme but legal codes, and words holding reserved codes, so an off-by-one counter load or a field read from the wrong bit position shows up as a distance that is wrong by a fixed amount. It holds a second-bank activate pending across an intervening precharge and checks that only a column command releases it; a gate that cleared the hold on any command would grant early. It also holds the program strobe high through reset and checks that nothing is captured, and it checks that back-to-back reads give adjacent valid strobes at both the shortest and the longest CAS latency, where a single-slot latency timer would drop the second strobe.

// File: rtl/sdram_gate_pkg.sv
package sdram_gate_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int          CFG_W       = 32;
  localparam logic [31:0] CFG_RESET   = 32'h2A73_3225;

  // field offsets; position is fixed by the configuration word layout
  localparam int CL_LSB  = 28;
  localparam int RC_LSB  = 24;
  localparam int RAS_LSB = 20;
  localparam int RP_LSB  = 16;
  localparam int RCD_LSB = 12;
  localparam int RRD_LSB = 8;

  localparam int LONG_CODE_W  = 4;
  localparam int SHORT_CODE_W = 3;
  localparam int LONG_CLK_W   = LONG_CODE_W + 1;
  localparam int SHORT_CLK_W  = SHORT_CODE_W;
  localparam int LONG_CNT_W   = LONG_CODE_W;
  localparam int SHORT_CNT_W  = SHORT_CODE_W;
  localparam int MIN_CL       = 2;
  localparam int MAX_CL       = (1 << SHORT_CODE_W) - 1;

  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_REF  = 3'd5
  } cmd_e;

  typedef struct packed {
    logic [LONG_CLK_W-1:0]  rc;
    logic [LONG_CLK_W-1:0]  ras;
    logic [SHORT_CLK_W-1:0] rp;
    logic [SHORT_CLK_W-1:0] rcd;
    logic [SHORT_CLK_W-1:0] rrd;
    logic [SHORT_CLK_W-1:0] cl;
  } timing_t;

  // 4-bit code n -> n+1 clocks; code 0 -> slowest (16)
  function automatic logic [LONG_CLK_W-1:0] dec_long(input logic [LONG_CODE_W-1:0] c);
    if (c == '0) return LONG_CLK_W'(1 << LONG_CODE_W);
    return LONG_CLK_W'(c) + LONG_CLK_W'(1);
  endfunction

  // 3-bit code n -> n clocks; code 0 -> slowest (7)
  function automatic logic [SHORT_CLK_W-1:0] dec_short(input logic [SHORT_CODE_W-1:0] c);
    if (c == '0) return '1;
    return c;
  endfunction

  // CAS codes below MIN_CL -> slowest
  function automatic logic [SHORT_CLK_W-1:0] dec_cas(input logic [SHORT_CODE_W-1:0] c);
    if (int'(c) < MIN_CL) return SHORT_CLK_W'(MAX_CL);
    return c;
  endfunction

  function automatic timing_t unpack_cfg(input logic [CFG_W-1:0] w);
    timing_t t;
    t.cl  = dec_cas  (w[CL_LSB  +: SHORT_CODE_W]);
    t.rc  = dec_long (w[RC_LSB  +: LONG_CODE_W]);
    t.ras = dec_long (w[RAS_LSB +: LONG_CODE_W]);
    t.rp  = dec_short(w[RP_LSB  +: SHORT_CODE_W]);
    t.rcd = dec_short(w[RCD_LSB +: SHORT_CODE_W]);
    t.rrd = dec_short(w[RRD_LSB +: SHORT_CODE_W]);
    return t;
  endfunction

  function automatic logic cfg_has_reserved(input logic [CFG_W-1:0] w);
    return (int'(w[CL_LSB +: SHORT_CODE_W]) < MIN_CL) ||
           (w[RC_LSB  +: LONG_CODE_W]  == '0) ||
           (w[RAS_LSB +: LONG_CODE_W]  == '0) ||
           (w[RP_LSB  +: SHORT_CODE_W] == '0) ||
           (w[RCD_LSB +: SHORT_CODE_W] == '0) ||
           (w[RRD_LSB +: SHORT_CODE_W] == '0);
  endfunction

  // a spacing of n clocks loads n-1: counter reads zero n cycles after the grant
  function automatic logic [LONG_CNT_W-1:0] load_long(input logic [LONG_CLK_W-1:0] clocks);
    return LONG_CNT_W'(clocks - LONG_CLK_W'(1));
  endfunction

  function automatic logic [SHORT_CNT_W-1:0] load_short(input logic [SHORT_CLK_W-1:0] clocks);
    return clocks - SHORT_CLK_W'(1);
  endfunction

endpackage

// File: rtl/sdram_gate_cfg.sv
module sdram_gate_cfg
  import sdram_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             cfg_prog,
  output timing_t          tim,
  output logic             cfg_err
);
  timeunit 1ns;
  timeprecision 1ps;

  logic prog_q;
  logic capture;

  assign capture = cfg_prog && !prog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q  <= 1'b1;
      tim     <= unpack_cfg(CFG_RESET);
      cfg_err <= 1'b0;
    end else begin
      prog_q <= cfg_prog;
      if (capture) begin
        tim <= unpack_cfg(cfg_word);
        if (cfg_has_reserved(cfg_word)) cfg_err <= 1'b1;
      end
    end
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(cfg_prog) |=> $stable(tim));

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

endmodule

// File: rtl/sdram_gate_bank.sv
module sdram_gate_bank
  import sdram_gate_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LONG_CLK_W-1:0]  tras,
  input  logic [SHORT_CLK_W-1:0] trcd,
  input  logic [SHORT_CLK_W-1:0] trp,
  input  logic                   act_go,
  input  logic                   pre_go,
  output logic                   ras_done,
  output logic                   rcd_done,
  output logic                   rp_done
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [LONG_CNT_W-1:0]  ras_cnt;
  logic [SHORT_CNT_W-1:0] rcd_cnt;
  logic [SHORT_CNT_W-1:0] rp_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_cnt <= '0;
      rcd_cnt <= '0;
      rp_cnt  <= '0;
    end else begin
      if (act_go)             ras_cnt <= load_long(tras);
      else if (ras_cnt != '0) ras_cnt <= ras_cnt - LONG_CNT_W'(1);

      if (act_go)             rcd_cnt <= load_short(trcd);
      else if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - SHORT_CNT_W'(1);

      if (pre_go)             rp_cnt <= load_short(trp);
      else if (rp_cnt != '0)  rp_cnt <= rp_cnt - SHORT_CNT_W'(1);
    end
  end

  assign ras_done = (ras_cnt == '0);
  assign rcd_done = (rcd_cnt == '0);
  assign rp_done  = (rp_cnt  == '0);

  // R4
  ras_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |=> !ras_done);

  // R5
  rcd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_go && trcd > SHORT_CLK_W'(1)) |=> !rcd_done);

  // R6
  rp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_go && trp > SHORT_CLK_W'(1)) |=> !rp_done);

endmodule

// File: rtl/sdram_gate_global.sv
module sdram_gate_global
  import sdram_gate_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LONG_CLK_W-1:0]  trc,
  input  logic [SHORT_CLK_W-1:0] trrd,
  input  logic                   act_go,
  input  logic                   rw_go,
  input  logic                   ref_go,
  input  logic [BANK_W-1:0]      act_bank,
  output logic                   rc_done,
  output logic                   act_space_ok
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [LONG_CNT_W-1:0]  rc_cnt;
  logic [SHORT_CNT_W-1:0] rrd_cnt;
  logic                   act_hold;
  logic [BANK_W-1:0]      last_bank;
  logic                   same_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_cnt    <= '0;
      rrd_cnt   <= '0;
      act_hold  <= 1'b0;
      last_bank <= '0;
    end else begin
      if (ref_go)            rc_cnt <= load_long(trc);
      else if (rc_cnt != '0) rc_cnt <= rc_cnt - LONG_CNT_W'(1);

      if (act_go)             rrd_cnt <= load_short(trrd);
      else if (rrd_cnt != '0) rrd_cnt <= rrd_cnt - SHORT_CNT_W'(1);

      if (act_go)     act_hold <= 1'b1;
      else if (rw_go) act_hold <= 1'b0;

      if (act_go) last_bank <= act_bank;
    end
  end

  assign same_bank    = (act_bank == last_bank);
  assign rc_done      = (rc_cnt == '0);
  assign act_space_ok = same_bank || ((rrd_cnt == '0) && !act_hold);

  // R7
  ref_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_go |=> !rc_done);

  // R9
  act_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_go && $past(act_go)) |-> act_bank == $past(act_bank));

endmodule

// File: rtl/sdram_gate_rdpipe.sv
module sdram_gate_rdpipe
  import sdram_gate_pkg::*;
#(
  parameter int DEPTH = MAX_CL
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SHORT_CLK_W-1:0] cl,
  input  logic                   rd_go,
  output logic                   rdata_valid
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DEPTH-1:0] sr_q;
  logic [DEPTH-1:0] sr_n;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    logic from_above;
    if (i == DEPTH - 1) begin : g_last
      assign from_above = 1'b0;
    end else begin : g_mid
      assign from_above = sr_q[i+1];
    end
    // a read granted now lands in slot cl-1, reaching slot 0 cl cycles later
    assign sr_n[i] = from_above | (rd_go && (int'(cl) == i + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_n;
  end

  assign rdata_valid = sr_q[0];

  // R11
  rd_tracked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> (sr_q != '0));

endmodule

// File: rtl/sdram_cmd_gate.sv
module sdram_cmd_gate
  import sdram_gate_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  parameter int RD_DEPTH  = MAX_CL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_word,
  input  logic              cfg_prog,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  output logic              grant,
  output logic              rdata_valid,
  output logic              config_error
);
  timeunit 1ns;
  timeprecision 1ps;

  timing_t tim;
  cmd_e    cmd;

  logic [NUM_BANKS-1:0] bank_sel;
  logic [NUM_BANKS-1:0] ras_done;
  logic [NUM_BANKS-1:0] rcd_done;
  logic [NUM_BANKS-1:0] rp_done;

  logic ras_ok, rcd_ok, rp_ok;
  logic rc_done, act_space_ok;
  logic allow;
  logic act_go, rw_go, rd_go, pre_go, ref_go;

  sdram_gate_cfg i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_word (cfg_word),
    .cfg_prog (cfg_prog),
    .tim      (tim),
    .cfg_err  (config_error)
  );

  assign cmd = cmd_e'(req_cmd);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_sel[b] = (req_bank == BANK_W'(b));

    sdram_gate_bank i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .tras     (tim.ras),
      .trcd     (tim.rcd),
      .trp      (tim.rp),
      .act_go   (act_go && bank_sel[b]),
      .pre_go   (pre_go && bank_sel[b]),
      .ras_done (ras_done[b]),
      .rcd_done (rcd_done[b]),
      .rp_done  (rp_done[b])
    );
  end

  assign ras_ok = |(ras_done & bank_sel);
  assign rcd_ok = |(rcd_done & bank_sel);
  assign rp_ok  = |(rp_done  & bank_sel);

  sdram_gate_global #(.BANK_W(BANK_W)) i_global (
    .clk          (clk),
    .rst_n        (rst_n),
    .trc          (tim.rc),
    .trrd         (tim.rrd),
    .act_go       (act_go),
    .rw_go        (rw_go),
    .ref_go       (ref_go),
    .act_bank     (req_bank),
    .rc_done      (rc_done),
    .act_space_ok (act_space_ok)
  );

  always_comb begin
    case (cmd)
      CMD_ACT:        allow = rp_ok && rc_done && act_space_ok;
      CMD_RD, CMD_WR: allow = rcd_ok;
      CMD_PRE:        allow = ras_ok;
      CMD_REF:        allow = rc_done;
      default:        allow = 1'b0;
    endcase
  end

  assign grant  = rst_n && req_valid && allow;
  assign act_go = grant && (cmd == CMD_ACT);
  assign rd_go  = grant && (cmd == CMD_RD);
  assign rw_go  = grant && (cmd == CMD_RD || cmd == CMD_WR);
  assign pre_go = grant && (cmd == CMD_PRE);
  assign ref_go = grant && (cmd == CMD_REF);

  sdram_gate_rdpipe #(.DEPTH(RD_DEPTH)) i_rdpipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .cl          (tim.cl),
    .rd_go       (rd_go),
    .rdata_valid (rdata_valid)
  );

  // R10
  grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> req_valid);

endmodule

// File: tb/test_sdram_cmd_gate.sv
module test_sdram_cmd_gate;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [2:0] C_IDLE = 3'd0;
  localparam logic [2:0] C_ACT  = 3'd1;
  localparam logic [2:0] C_RD   = 3'd2;
  localparam logic [2:0] C_WR   = 3'd3;
  localparam logic [2:0] C_PRE  = 3'd4;
  localparam logic [2:0] C_REF  = 3'd5;

  localparam logic [31:0] W_DEF  = 32'h2A73_3225; // CL2 RC11 RAS8 RP3 RCD3 RRD2
  localparam logic [31:0] W_FAST = 32'h7F17_1100; // CL7 RC16 RAS2 RP7 RCD1 RRD1
  localparam logic [31:0] W_NRAS = 32'h2A03_3225; // RAS code 0
  localparam logic [31:0] W_NRP  = 32'h2A70_3225; // RP code 0
  localparam logic [31:0] W_NRCD = 32'h2A73_0225; // RCD code 0
  localparam logic [31:0] W_RSVB = 32'hAA7B_BA25; // default + bits 31,19,15,11 set
  localparam logic [31:0] W_RRD5 = 32'h2A73_1525; // RCD1 RRD5
  localparam logic [31:0] W_NCL  = 32'h1A73_3225; // CAS code 1

  typedef struct packed {
    logic [31:0] word;
    logic [2:0]  ca;
    logic [1:0]  ba;
    logic [2:0]  cb;
    logic [1:0]  bb;
    logic [4:0]  gap;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{W_DEF,  C_ACT, 2'd0, C_PRE, 2'd0, 5'd8,  1'b0, 4'd4},  // R4 R3
    '{W_DEF,  C_ACT, 2'd0, C_RD,  2'd0, 5'd3,  1'b0, 4'd5},  // R5
    '{W_DEF,  C_ACT, 2'd2, C_WR,  2'd2, 5'd3,  1'b0, 4'd5},  // R5
    '{W_DEF,  C_PRE, 2'd1, C_ACT, 2'd1, 5'd3,  1'b0, 4'd6},  // R6
    '{W_DEF,  C_REF, 2'd0, C_ACT, 2'd0, 5'd11, 1'b0, 4'd7},  // R7
    '{W_DEF,  C_REF, 2'd0, C_REF, 2'd0, 5'd11, 1'b0, 4'd7},  // R7
    '{W_DEF,  C_ACT, 2'd0, C_PRE, 2'd1, 5'd1,  1'b0, 4'd8},  // R8 banks independent
    '{W_FAST, C_ACT, 2'd0, C_PRE, 2'd0, 5'd2,  1'b0, 4'd1},  // R1
    '{W_FAST, C_ACT, 2'd3, C_RD,  2'd3, 5'd1,  1'b0, 4'd1},  // R1
    '{W_FAST, C_PRE, 2'd0, C_ACT, 2'd0, 5'd7,  1'b0, 4'd1},  // R1
    '{W_FAST, C_REF, 2'd0, C_ACT, 2'd3, 5'd16, 1'b0, 4'd1},  // R1
    '{W_NRAS, C_ACT, 2'd0, C_PRE, 2'd0, 5'd16, 1'b1, 4'd12}, // R12
    '{W_NRP,  C_PRE, 2'd0, C_ACT, 2'd0, 5'd7,  1'b1, 4'd12}, // R12
    '{W_NRCD, C_ACT, 2'd0, C_RD,  2'd0, 5'd7,  1'b1, 4'd12}, // R12
    '{W_RSVB, C_ACT, 2'd0, C_PRE, 2'd0, 5'd8,  1'b0, 4'd13}, // R13
    '{W_RSVB, C_REF, 2'd0, C_ACT, 2'd0, 5'd11, 1'b0, 4'd13}  // R13
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = W_DEF;
  logic        cfg_prog = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_cmd = C_IDLE;
  logic [1:0]  req_bank = 2'd0;
  logic        grant, rdata_valid, config_error;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  sdram_cmd_gate i_sdram_cmd_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_word     (cfg_word),
    .cfg_prog     (cfg_prog),
    .req_valid    (req_valid),
    .req_cmd      (req_cmd),
    .req_bank     (req_bank),
    .grant        (grant),
    .rdata_valid  (rdata_valid),
    .config_error (config_error)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_prog = 1'b0; req_valid = 1'b0; req_cmd = C_IDLE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic program_word(input logic [31:0] w);
    cfg_word = w; cfg_prog = 1'b0;
    @(negedge clk);
    cfg_prog = 1'b1;
    @(negedge clk);
    cfg_prog = 1'b0;
    @(negedge clk);
  endtask

  // present a request from a falling edge until granted or lim cycles pass
  task automatic issue(input logic [2:0] c, input logic [1:0] b, input int lim, output int at);
    at = -1;
    req_valid = 1'b1; req_cmd = c; req_bank = b;
    for (int i = 0; i < lim; i++) begin
      #5;
      if (grant) at = cyc;
      @(negedge clk);
      if (at >= 0) break;
    end
    req_valid = 1'b0;
  endtask

  // record rdata_valid offsets relative to cycle t0 over n cycles
  task automatic watch_rv(input int t0, input int n, output logic [15:0] seen);
    seen = '0;
    for (int i = 0; i < n; i++) begin
      #5;
      if (rdata_valid && (cyc - t0) >= 0 && (cyc - t0) < 16) seen[cyc - t0] = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t v;
    int ta, tb, tr, nb;
    logic [15:0] seen;

    // R3 reset state
    do_reset();
    #5;
    chk("R3 grant after reset", int'(grant), 0);
    chk("R3 rdata_valid after reset", int'(rdata_valid), 0);
    chk("R3 config_error after reset", int'(config_error), 0);
    @(negedge clk);

    // table of spacing vectors
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      do_reset();
      program_word(v.word);
      issue(v.ca, v.ba, 40, ta);
      issue(v.cb, v.bb, 40, tb);
      chk($sformatf("R%0d vector %0d gap", v.req, i), (ta < 0 || tb < 0) ? -1 : tb - ta, int'(v.gap));
      #5;
      chk($sformatf("R%0d vector %0d config_error", v.req, i), int'(config_error), int'(v.err));
      @(negedge clk);
    end

    // R10 illegal codes, idle code and dropped valid
    do_reset();
    issue(3'd6, 2'd0, 10, ta);   chk("R10 code 6 never granted", ta, -1);
    issue(3'd7, 2'd1, 10, ta);   chk("R10 code 7 never granted", ta, -1);
    issue(C_IDLE, 2'd0, 10, ta); chk("R10 idle code never granted", ta, -1);
    req_cmd = C_ACT; req_bank = 2'd0; req_valid = 1'b0; nb = 0;
    for (int i = 0; i < 5; i++) begin #5; if (grant) nb++; @(negedge clk); end
    chk("R10 no grant without req_valid", nb, 0);
    issue(C_ACT, 2'd0, 3, ta);   chk("R10 legal request granted at once", ta >= 0 ? 1 : 0, 1);

    // R9 activate hold released only by a column command
    do_reset();
    issue(C_ACT, 2'd0, 5, ta);
    issue(C_ACT, 2'd1, 30, tb);  chk("R9 second-bank ACT held", tb, -1);
    issue(C_PRE, 2'd0, 20, tb);  chk("R9 PRE still granted", tb >= 0 ? 1 : 0, 1);
    issue(C_REF, 2'd0, 20, tb);  chk("R9 REF still granted", tb >= 0 ? 1 : 0, 1);
    repeat (12) @(negedge clk);
    issue(C_ACT, 2'd1, 20, tb);  chk("R9 ACT held across PRE and REF", tb, -1);
    issue(C_WR, 2'd0, 5, ta);
    issue(C_ACT, 2'd1, 20, tb);  chk("R9 ACT released by WRITE", (ta < 0 || tb < 0) ? -1 : tb - ta, 1);

    // R8 activate-to-activate spacing with a read between
    do_reset();
    program_word(W_RRD5);
    issue(C_ACT, 2'd0, 5, ta);
    issue(C_RD, 2'd0, 5, tr);    chk("R8 read after tRCD 1", tr - ta, 1);
    issue(C_ACT, 2'd1, 20, tb);  chk("R8 ACT to ACT spacing 5", (tb < 0) ? -1 : tb - ta, 5);

    // R2 strobe held high through reset and a word change while high
    @(negedge clk);
    rst_n = 1'b0; cfg_prog = 1'b1; cfg_word = W_FAST; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    issue(C_ACT, 2'd0, 5, ta);
    issue(C_PRE, 2'd0, 20, tb);  chk("R2 high strobe through reset captures nothing", tb - ta, 8);
    cfg_word = W_NRAS;
    repeat (2) @(negedge clk);
    #5; chk("R2 word change without edge", int'(config_error), 0); @(negedge clk);
    cfg_word = W_FAST; cfg_prog = 1'b0;
    @(negedge clk); cfg_prog = 1'b1; @(negedge clk); cfg_prog = 1'b0;
    issue(C_ACT, 2'd0, 20, ta);
    issue(C_PRE, 2'd0, 20, tb);  chk("R2 rising edge captures word", tb - ta, 2);

    // R11 CAS latency, single and back-to-back reads
    do_reset();
    issue(C_ACT, 2'd0, 5, ta);
    issue(C_RD, 2'd0, 10, tr);
    watch_rv(tr, 10, seen);      chk("R11 CL2 single read", int'(seen), 16'h0004);
    issue(C_RD, 2'd0, 5, tr);
    issue(C_RD, 2'd0, 5, tb);    chk("R11 reads adjacent", tb - tr, 1);
    watch_rv(tr, 10, seen);      chk("R11 CL2 back-to-back strobes", int'(seen), 16'h000C);
    do_reset();
    program_word(W_FAST);
    issue(C_ACT, 2'd2, 5, ta);
    issue(C_RD, 2'd2, 5, tr);
    issue(C_RD, 2'd2, 5, tb);
    watch_rv(tr, 12, seen);      chk("R11 CL7 back-to-back strobes", int'(seen), 16'h0180);

    // R12 reserved CAS code and sticky error
    do_reset();
    program_word(W_NCL);
    #5; chk("R12 reserved CAS sets error", int'(config_error), 1); @(negedge clk);
    issue(C_ACT, 2'd0, 5, ta);
    issue(C_RD, 2'd0, 10, tr);
    watch_rv(tr, 10, seen);      chk("R12 reserved CAS acts as 7", int'(seen), 16'h0080);
    program_word(W_DEF);
    #5; chk("R12 error sticky after valid word", int'(config_error), 1); @(negedge clk);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule